// File: doc/BRIEF.md
# Shared Eight-Pixel Readout Arbiter

This block serves a group of eight pixels, arranged two by four, that share one readout path. Each pixel registers its own hit: a coarse timestamp, a fine timestamp that subdivides one coarse step into fifteen parts, and a 10-bit time-over-threshold (ToT) value. While a pixel's hit waits to be read, the pixel is pending. Every packet the block sends carries exactly one pixel's data.

The group gets onto the column bus by token passing. When the token arrives and at least one pixel is pending, the block picks one pending pixel in round-robin order. It shifts that pixel's packet out one bit per clock, most significant bit first. After the last bit it clears that pixel's pending flag and passes the token on. If no pixel is pending, the token is passed on at once.

A hit on a pixel that is still pending is dropped. Each dropped hit increments a saturating counter.

Top module: `pxr_group_readout`

## Requirements
- R1: While reset is asserted and right after it is released, `ser_valid`, `tok_out` and `lost_count` are all 0.
- R2: A packet is 31 bits, sent MSB first: pixel index in bits [30:28], coarse time in [27:14], fine time in [13:10], ToT in [9:0]. The first bit is on `ser_data` with `ser_valid` high in the cycle after the edge that samples `tok_in`, and one bit follows per cycle.
- R3: No packet bit is driven without a token. `ser_valid` rises only in the cycle after `tok_in` was sampled high, and it is never high together with `tok_out`.
- R4: If `tok_in` is sampled while no pixel is pending, `tok_out` is high for exactly the next cycle and no packet is sent.
- R5: `tok_out` is high in the cycle right after the last packet bit. Each token yields at most one packet.
- R6: The winner is the first pending pixel found when counting upward, with wrap-around, from the index after the last pixel served. After reset the search starts at pixel 0.
- R7: A hit on a pending pixel does not change its stored data and adds 1 to `lost_count`. Hits on several pending pixels in the same cycle each add 1.
- R8: `lost_count` never decreases and holds at 2^LOST_W-1 once it gets there.
- R9: A pixel's pending flag clears only at the edge after its last bit. A hit on that pixel while its packet is in flight, up to and including that edge, is lost. A hit that comes later is accepted.
- R10: A `tok_in` pulse that arrives while a packet is being sent is ignored. It neither lengthens the packet nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | NPIX | One-cycle hit strobe per pixel |
| hit_coarse | input | NPIX*CT_W | Coarse time per pixel, pixel i at [i*CT_W +: CT_W] |
| hit_fine | input | NPIX*FT_W | Fine time per pixel (0 to 14) |
| hit_tot | input | NPIX*TOT_W | Time-over-threshold per pixel |
| tok_in | input | 1 | One-cycle token arrival from the column |
| tok_out | output | 1 | One-cycle token pass to the next group |
| ser_valid | output | 1 | High while packet bits are on ser_data |
| ser_data | output | 1 | Serial packet bit, MSB first |
| lost_count | output | LOST_W | Saturating count of dropped hits |

## Verification
The bench builds the block with eight pixels, a 14-bit coarse field, a 4-bit fine field and a 10-bit ToT field, so the packet is the full 31-bit layout. It sets LOST_W to 3, which makes the counter saturate at 7; a handful of repeated hits on one pending pixel then reaches the ceiling and stays there. With eight pixels the round-robin search can be made to wrap past index 7 back to low indices. Hits and token pulses can also be injected at chosen bit positions of a packet in flight.

// File: rtl/pxr_pkg.sv
// Package: shared types for the pixel-group readout arbiter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pxr_pkg;
    // Serializer state: waiting for a token, or shifting a packet.
    typedef enum logic [0:0] {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } sh_state_t;
endpackage

// File: rtl/pxr_pixel_slot.sv
// Module: one pixel's hit store.
// Captures coarse/fine/ToT on a hit when the pixel is not pending and sets
// pending. A hit while pending is reported on lost_o and leaves the data
// alone. A clear request drops pending; it wins over a hit in the same cycle.
module pxr_pixel_slot #(
    parameter int CT_W  = 14,
    parameter int FT_W  = 4,
    parameter int TOT_W = 10,
    localparam int WORD_W = CT_W + FT_W + TOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [CT_W-1:0]   coarse_i,
    input  logic [FT_W-1:0]   fine_i,
    input  logic [TOT_W-1:0]  tot_i,
    input  logic              clr_i,
    output logic              pend_o,
    output logic [WORD_W-1:0] word_o,
    output logic              lost_o
);
    logic              pend_q;
    logic [WORD_W-1:0] word_q;

    // Pending flag: set by an accepted hit, cleared after readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end else if (hit_i && !pend_q) begin
            pend_q <= 1'b1;
        end
    end

    // Data store: written only by a hit on a free pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (hit_i && !pend_q) begin
            word_q <= {coarse_i, fine_i, tot_i};
        end
    end

    assign pend_o = pend_q;
    assign word_o = word_q;
    assign lost_o = hit_i & pend_q;
endmodule

// File: rtl/pxr_rr_pick.sv
// Module: round-robin winner search.
// Purely combinational. Looks for the first set bit of pend_i, starting at
// last_i+1 and wrapping around. Assumes NPIX >= 2.
module pxr_rr_pick #(
    parameter int NPIX = 8,
    localparam int IDX_W = $clog2(NPIX)
) (
    input  logic [NPIX-1:0]  pend_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             any_o,
    output logic [IDX_W-1:0] win_o
);
    // Search loop: the first hit in rotated order wins.
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int k = 1; k <= NPIX; k++) begin
            int cand;
            cand = (int'(last_i) + k) % NPIX;
            if (!any_o && pend_i[cand]) begin
                any_o = 1'b1;
                win_o = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/pxr_serializer.sv
// Module: token-gated packet shifter.
// On a sampled token with a winner available it loads the packet and shifts
// it out MSB first, one bit per cycle. It then pulses tok_out and done_o
// (done_o accompanies the last bit). With no winner the token is passed at
// once. Tokens that arrive while sending are ignored.
module pxr_serializer
    import pxr_pkg::*;
#(
    parameter int PKT_W = 31,
    parameter int IDX_W = 3,
    parameter logic [IDX_W-1:0] LAST_RST = '1,
    localparam int CNT_W = $clog2(PKT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_i,
    input  logic             any_i,
    input  logic [IDX_W-1:0] win_i,
    input  logic [PKT_W-1:0] pkt_i,
    output logic             ser_valid_o,
    output logic             ser_data_o,
    output logic             tok_o,
    output logic             done_o,
    output logic [IDX_W-1:0] cur_o,
    output logic [IDX_W-1:0] last_o
);
    sh_state_t        st_q;
    logic [PKT_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] last_q;
    logic             tok_q;
    logic             at_end;

    assign at_end = (st_q == SH_SEND) && (cnt_q == CNT_W'(PKT_W - 1));

    // Control and datapath: grant, shift, bit count and token pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SH_IDLE;
            sh_q   <= '0;
            cnt_q  <= '0;
            cur_q  <= '0;
            last_q <= LAST_RST;
            tok_q  <= 1'b0;
        end else begin
            tok_q <= 1'b0;
            case (st_q)
                SH_IDLE: begin
                    if (tok_i) begin
                        if (any_i) begin
                            st_q   <= SH_SEND;
                            sh_q   <= pkt_i;
                            cnt_q  <= '0;
                            cur_q  <= win_i;
                            last_q <= win_i;
                        end else begin
                            tok_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    sh_q  <= {sh_q[PKT_W-2:0], 1'b0};
                    cnt_q <= cnt_q + 1'b1;
                    if (at_end) begin
                        st_q  <= SH_IDLE;
                        tok_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign ser_valid_o = (st_q == SH_SEND);
    assign ser_data_o  = sh_q[PKT_W-1];
    assign tok_o       = tok_q;
    assign done_o      = at_end;
    assign cur_o       = cur_q;
    assign last_o      = last_q;
endmodule

// File: rtl/pxr_lost_ctr.sv
// Module: saturating lost-hit counter.
// Adds the number of set bits of lost_i each cycle and clamps at all ones.
module pxr_lost_ctr #(
    parameter int NPIX   = 8,
    parameter int LOST_W = 8,
    localparam int INC_W = $clog2(NPIX + 1),
    localparam int SUM_W = ((LOST_W > INC_W) ? LOST_W : INC_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIX-1:0]   lost_i,
    output logic [LOST_W-1:0] count_o
);
    logic [LOST_W-1:0] cnt_q;
    logic [SUM_W-1:0]  sum;

    // Next value: widened sum of the count and this cycle's losses.
    always_comb begin
        sum = SUM_W'(cnt_q) + SUM_W'($countones(lost_i));
    end

    // Counter register with clamp at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sum > SUM_W'({LOST_W{1'b1}})) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= sum[LOST_W-1:0];
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/pxr_group_readout.sv
// Module: top of the shared eight-pixel readout arbiter.
// One slot per pixel holds a pending hit. A round-robin picker chooses the
// next pixel, and a token-gated serializer sends {index, coarse, fine, ToT}.
// Lost hits are counted with saturation.
// Assumes tok_in is a one-cycle pulse and that fine time stays in 0..14.
module pxr_group_readout #(
    parameter int NPIX   = 8,
    parameter int CT_W   = 14,
    parameter int FT_W   = 4,
    parameter int TOT_W  = 10,
    parameter int LOST_W = 8,
    localparam int IDX_W  = $clog2(NPIX),
    localparam int WORD_W = CT_W + FT_W + TOT_W,
    localparam int PKT_W  = IDX_W + WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIX-1:0]       hit_valid,
    input  logic [NPIX*CT_W-1:0]  hit_coarse,
    input  logic [NPIX*FT_W-1:0]  hit_fine,
    input  logic [NPIX*TOT_W-1:0] hit_tot,
    input  logic                  tok_in,
    output logic                  tok_out,
    output logic                  ser_valid,
    output logic                  ser_data,
    output logic [LOST_W-1:0]     lost_count
);
    logic [NPIX-1:0]   pend;
    logic [NPIX-1:0]   lost;
    logic [NPIX-1:0]   clr;
    logic [WORD_W-1:0] words [NPIX];
    logic              any;
    logic [IDX_W-1:0]  win;
    logic [IDX_W-1:0]  last;
    logic [IDX_W-1:0]  cur;
    logic              done;
    logic [PKT_W-1:0]  pkt;

    // Per-pixel slots and their clear strobes.
    for (genvar i = 0; i < NPIX; i++) begin : g_slot
        assign clr[i] = done && (cur == IDX_W'(i));
        pxr_pixel_slot #(
            .CT_W  (CT_W),
            .FT_W  (FT_W),
            .TOT_W (TOT_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit_valid[i]),
            .coarse_i (hit_coarse[i*CT_W +: CT_W]),
            .fine_i   (hit_fine[i*FT_W +: FT_W]),
            .tot_i    (hit_tot[i*TOT_W +: TOT_W]),
            .clr_i    (clr[i]),
            .pend_o   (pend[i]),
            .word_o   (words[i]),
            .lost_o   (lost[i])
        );
    end

    pxr_rr_pick #(.NPIX(NPIX)) u_pick (
        .pend_i (pend),
        .last_i (last),
        .any_o  (any),
        .win_o  (win)
    );

    // Packet assembly for the current winner.
    assign pkt = {win, words[win]};

    pxr_serializer #(
        .PKT_W    (PKT_W),
        .IDX_W    (IDX_W),
        .LAST_RST (IDX_W'(NPIX - 1))
    ) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_i       (tok_in),
        .any_i       (any),
        .win_i       (win),
        .pkt_i       (pkt),
        .ser_valid_o (ser_valid),
        .ser_data_o  (ser_data),
        .tok_o       (tok_out),
        .done_o      (done),
        .cur_o       (cur),
        .last_o      (last)
    );

    pxr_lost_ctr #(
        .NPIX   (NPIX),
        .LOST_W (LOST_W)
    ) u_lost (
        .clk     (clk),
        .rst_n   (rst_n),
        .lost_i  (lost),
        .count_o (lost_count)
    );
endmodule

// File: rtl/pxr_group_readout_chk.sv
// Module: property checker for pxr_group_readout, attached through bind.
// Tracks the packet length with its own counter.
module pxr_group_readout_chk #(
    parameter int PKT_W  = 31,
    parameter int LOST_W = 8,
    localparam int BC_W = $clog2(PKT_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_in,
    input logic              tok_out,
    input logic              ser_valid,
    input logic [LOST_W-1:0] lost_count
);
    logic [BC_W-1:0] bitcnt;

    // Bit counter: position of the current packet bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
        end else if (ser_valid) begin
            bitcnt <= bitcnt + 1'b1;
        end else begin
            bitcnt <= '0;
        end
    end

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_valid && tok_out));
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> $past(tok_in));
    p_len_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> (bitcnt < BC_W'(PKT_W)));
    p_len_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_valid) |-> ($past(bitcnt) == BC_W'(PKT_W - 1)));
    p_pass_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_valid) |-> tok_out);
    p_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost_count >= $past(lost_count));
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lost_count) == {LOST_W{1'b1}}) |-> (lost_count == {LOST_W{1'b1}}));
endmodule

bind pxr_group_readout pxr_group_readout_chk #(
    .PKT_W  (PKT_W),
    .LOST_W (LOST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_in     (tok_in),
    .tok_out    (tok_out),
    .ser_valid  (ser_valid),
    .lost_count (lost_count)
);

// File: tb/sim_pxr_group_readout.sv
`timescale 1ns/1ps
// Directed bench for pxr_group_readout; one task per scenario.
module sim_pxr_group_readout;
    localparam int NPIX   = 8;
    localparam int CT_W   = 14;
    localparam int FT_W   = 4;
    localparam int TOT_W  = 10;
    localparam int LOST_W = 3;
    localparam int PKT_W  = 3 + CT_W + FT_W + TOT_W;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NPIX-1:0]       hit_valid = '0;
    logic [NPIX*CT_W-1:0]  hit_coarse = '0;
    logic [NPIX*FT_W-1:0]  hit_fine = '0;
    logic [NPIX*TOT_W-1:0] hit_tot = '0;
    logic                  tok_in = 1'b0;
    logic                  tok_out;
    logic                  ser_valid;
    logic                  ser_data;
    logic [LOST_W-1:0]     lost_count;

    int checks = 0;
    int errors = 0;
    int exp_lost = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pxr_group_readout #(
        .NPIX(NPIX), .CT_W(CT_W), .FT_W(FT_W), .TOT_W(TOT_W), .LOST_W(LOST_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_coarse(hit_coarse),
        .hit_fine(hit_fine), .hit_tot(hit_tot), .tok_in(tok_in), .tok_out(tok_out),
        .ser_valid(ser_valid), .ser_data(ser_data), .lost_count(lost_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PKT_W-1:0] mk(input int idx, input int c,
                                             input int f, input int t);
        return {3'(idx), CT_W'(c), FT_W'(f), TOT_W'(t)};
    endfunction

    function automatic int sat_add(input int a, input int n);
        return (a + n > 7) ? 7 : a + n;
    endfunction

    // Put a one-cycle hit on the pixels of mask, with data derived from seed.
    task automatic hits(input logic [NPIX-1:0] mask, input int seed);
        @(negedge clk);
        for (int i = 0; i < NPIX; i++) begin
            hit_coarse[i*CT_W +: CT_W] = CT_W'(seed * 97 + i * 13);
            hit_fine[i*FT_W +: FT_W]   = FT_W'((seed + i) % 15);
            hit_tot[i*TOT_W +: TOT_W]  = TOT_W'(seed * 31 + i);
        end
        hit_valid = mask;
        @(posedge clk); #1;
        hit_valid = '0;
    endtask

    function automatic logic [PKT_W-1:0] exp_pkt(input int idx, input int seed);
        return mk(idx, (seed * 97 + idx * 13) % (1 << CT_W), (seed + idx) % 15,
                  (seed * 31 + idx) % (1 << TOT_W));
    endfunction

    // Token with a packet expected; optional token or hit injected after bit inj_at.
    task automatic serve(input string req, input logic [PKT_W-1:0] expv,
                         input int inj_at, input bit inj_tok, input int inj_pix);
        logic [PKT_W-1:0] got;
        bit len_ok;
        got = '0;
        len_ok = 1'b1;
        @(negedge clk); tok_in = 1'b1;
        @(posedge clk); #1; tok_in = 1'b0;
        for (int k = 0; k < PKT_W; k++) begin
            @(negedge clk);
            if (!ser_valid || tok_out) len_ok = 1'b0;
            got = {got[PKT_W-2:0], ser_data};
            if (k == inj_at) begin
                if (inj_tok) tok_in = 1'b1;
                if (inj_pix >= 0) hit_valid[inj_pix] = 1'b1;
                @(posedge clk); #1;
                tok_in = 1'b0;
                hit_valid = '0;
            end
        end
        chk(len_ok, req, "ser_valid over packet", len_ok, 1);
        chk(got == expv, req, "packet", got, expv);
        @(negedge clk);
        chk(tok_out && !ser_valid, "R5", "token pass after last bit",
            {tok_out, ser_valid}, 2'b10);
        @(negedge clk);
        chk(!tok_out && !ser_valid, "R10", "single pass, no second packet",
            {tok_out, ser_valid}, 2'b00);
    endtask

    // Token with nothing pending.
    task automatic empty_token(input string req);
        @(negedge clk); tok_in = 1'b1;
        @(posedge clk); #1; tok_in = 1'b0;
        @(negedge clk);
        chk(tok_out && !ser_valid, req, "empty token passed", {tok_out, ser_valid}, 2'b10);
        @(negedge clk);
        chk(!tok_out && !ser_valid, req, "token pulse one cycle", {tok_out, ser_valid}, 2'b00);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!ser_valid && !tok_out && lost_count == 0, "R1", "outputs in reset",
            {ser_valid, tok_out, lost_count}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!ser_valid && !tok_out && lost_count == 0, "R1", "outputs after reset",
            {ser_valid, tok_out, lost_count}, 0);
    endtask

    // R3 no token means no output; R6 first search from 0; R2 fields.
    task automatic t_no_token_then_first();
        bit quiet;
        quiet = 1'b1;
        hits(8'b1010_0000, 1);
        repeat (10) begin
            @(negedge clk);
            if (ser_valid || tok_out) quiet = 1'b0;
        end
        chk(quiet, "R3", "no bits without token", quiet, 1);
        serve("R6", exp_pkt(5, 1), -1, 1'b0, -1);
        serve("R2", exp_pkt(7, 1), -1, 1'b0, -1);
    endtask

    task automatic t_empty();
        empty_token("R4");
    endtask

    // last served = 7; pending 1,3,6 -> expect 1,3,6; then wrap test.
    task automatic t_round_robin();
        hits(8'b0100_1010, 2);
        serve("R6", exp_pkt(1, 2), -1, 1'b0, -1);
        serve("R6", exp_pkt(3, 2), -1, 1'b0, -1);
        hits(8'b0000_0001, 3);
        serve("R6", exp_pkt(6, 2), -1, 1'b0, -1);
        serve("R6", exp_pkt(0, 3), -1, 1'b0, -1);
    endtask

    // Repeat hits on pending pixels: data kept, lost counted per pixel.
    task automatic t_lost_keep();
        hits(8'b0000_0100, 4);
        hits(8'b0000_0100, 5);
        exp_lost = sat_add(exp_lost, 1);
        @(negedge clk);
        chk(lost_count == exp_lost, "R7", "lost after repeat hit", lost_count, exp_lost);
        hits(8'b0101_0000, 6);
        hits(8'b0101_0000, 7);
        exp_lost = sat_add(exp_lost, 2);
        @(negedge clk);
        chk(lost_count == exp_lost, "R7", "two lost in one cycle", lost_count, exp_lost);
        serve("R7", exp_pkt(2, 4), -1, 1'b0, -1);
        serve("R7", exp_pkt(4, 6), -1, 1'b0, -1);
        serve("R7", exp_pkt(6, 6), -1, 1'b0, -1);
    endtask

    // Hit on the pixel in flight (even on its last bit edge) is lost.
    task automatic t_hit_during_send();
        hits(8'b0000_0010, 8);
        serve("R9", exp_pkt(1, 8), PKT_W - 1, 1'b0, 1);
        exp_lost = sat_add(exp_lost, 1);
        chk(lost_count == exp_lost, "R9", "hit on last bit lost", lost_count, exp_lost);
        empty_token("R9");
        hits(8'b0000_0010, 9);
        serve("R9", exp_pkt(1, 9), -1, 1'b0, -1);
    endtask

    task automatic t_token_during_send();
        hits(8'b0000_1000, 10);
        hits(8'b0010_0000, 11);
        serve("R10", exp_pkt(3, 10), 12, 1'b1, -1);
        serve("R10", exp_pkt(5, 11), -1, 1'b0, -1);
    endtask

    task automatic t_saturate();
        hits(8'b0000_0001, 12);
        for (int n = 0; n < 6; n++) begin
            hits(8'b0000_0001, 13 + n);
            exp_lost = sat_add(exp_lost, 1);
        end
        @(negedge clk);
        chk(lost_count == 7, "R8", "lost saturates", lost_count, 7);
        hits(8'b1111_1111, 30);
        @(negedge clk);
        chk(lost_count == 7, "R8", "lost holds at top", lost_count, 7);
    endtask

    initial begin
        t_reset();
        t_no_token_then_first();
        t_empty();
        t_round_robin();
        t_lost_keep();
        t_hit_during_send();
        t_token_during_send();
        t_saturate();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule